// File: doc/BRIEF.md
# Ethernet transmit frame encapsulator

This block turns the bytes of one outgoing frame, held in a first-word-fall-through byte FIFO, into a complete Ethernet byte stream. A new frame starts only when two things are true: the FIFO holds at least a programmed number of bytes, and a channel-permit input says the medium may be used. The block then emits seven preamble bytes and the start delimiter. After that it copies the payload from the FIFO until the byte marked as end of frame. Minimum-size padding and the frame check sequence are each optional, and both choices are taken once per frame.

The output is one byte per clock with a valid strobe and a last-byte marker. The byte value is given in line order with bit 0 first, so a later serialiser can shift it out least significant bit first. If the FIFO runs dry in the middle of a frame, the block drops the frame, flags an underflow for one cycle and returns to idle.

The controller has six named states:
- **IDLE**: waits for the start conditions.
- **PRE**: sends the preamble.
- **SFD**: sends the delimiter.
- **BODY**: copies the payload.
- **PAD**: inserts zero bytes.
- **FCS**: sends the four check bytes.

Transitions:
- IDLE→PRE when the start conditions hold.
- PRE→SFD after the seventh preamble byte.
- SFD→BODY always.
- BODY→PAD on the end-of-frame byte when padding is enabled and fewer than 60 bytes have been sent.
- BODY→FCS on the end-of-frame byte when no padding is needed and the check sequence is enabled.
- BODY→IDLE on the end-of-frame byte with nothing left to add, or on underflow.
- PAD→FCS or PAD→IDLE once the body reaches 60 bytes.
- FCS→IDLE after the fourth check byte.

Top module: `eth_tx_encap`

## Requirements
- R1: After reset the block is idle: tx_valid, tx_last, fifo_rd and underflow are all 0.
- R2: A frame starts only in a cycle where chan_ok=1, fifo_empty=0 and fifo_level >= start_level. pad_en and fcs_en are captured in that cycle, and later changes to them have no effect on the frame in progress.
- R3: The first output byte comes one cycle after the start condition. The first seven bytes are each 55h, one per cycle, so that the line sees 1,0,1,0... starting with a 1.
- R4: The byte after the preamble is the delimiter D5h.
- R5: Payload bytes follow in FIFO order, one per cycle. A byte is shown on tx_data while fifo_rd=1 in the same cycle, and fifo_last marks the final payload byte.
- R6: With padding enabled, a payload shorter than 60 bytes is followed by 00h bytes until the payload plus padding totals 60 bytes, so that the frame with its check sequence is 64 bytes.
- R7: With padding disabled, a short payload is sent unchanged and is followed directly by the check sequence, or by nothing.
- R8: With the check sequence enabled, four bytes follow the payload and padding. They carry the complement of a CRC-32 (polynomial 04C11DB7h, reflected, preset to all ones) computed over payload and padding. Byte k (k=0..3) carries bits 8k+7..8k of the complemented reflected register, which puts the x^31 term first on the line.
- R9: With the check sequence disabled, the frame ends after its last payload or pad byte.
- R10: tx_last is 1 exactly on the final byte of each completed frame.
- R11: If the FIFO is empty while payload is being sent, underflow is 1 for one cycle with tx_valid=0. The frame ends with no further bytes and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_level | input | LVL_W | Number of bytes in the FIFO |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_last | input | 1 | Head byte is the last byte of the frame |
| fifo_empty | input | 1 | FIFO holds no bytes |
| fifo_rd | output | 1 | Pop the head byte |
| start_level | input | LVL_W | Fill level needed to start a frame |
| chan_ok | input | 1 | Medium may be used |
| pad_en | input | 1 | Pad short frames (captured at start) |
| fcs_en | input | 1 | Append check sequence (captured at start) |
| tx_data | output | 8 | Output byte, bit 0 first on line |
| tx_valid | output | 1 | tx_data is valid |
| tx_last | output | 1 | Final byte of the frame |
| underflow | output | 1 | Frame dropped because the FIFO ran dry |

## Verification
The bench checks start gating with the threshold unmet and with the channel withheld. A block that ignored either condition would start early and send bytes that no entry in the scoreboard expects. It also flips pad_en and fcs_en just after a frame starts, which catches a design that reads these inputs live and adds or drops padding or the check sequence partway through. The bench sends payloads of exactly 60 bytes and of 70 bytes, where padding must not appear, and short payloads in every pad/check combination. These cases expose off-by-one pad lengths, a CRC that skips the padding, and misplaced tx_last. A frame cut short without its end marker must yield one underflow pulse and silence. A design that kept going would go on to emit check bytes or hang in BODY.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_BODY,
        ST_PAD,
        ST_FCS
    } txf_state_t;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;
    localparam int         FCS_LEN  = 4;
endpackage

// File: rtl/txf_crc32.sv
module txf_crc32 #(
    parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc_o
);
    logic [31:0] crc_q;

    function automatic logic [31:0] step_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= step_byte(crc_q, din);
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
    import txf_pkg::*;
#(
    parameter int LVL_W    = 8,
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_data,
    input  logic             fifo_last,
    input  logic             fifo_empty,
    input  logic [LVL_W-1:0] start_level,
    input  logic             chan_ok,
    input  logic             pad_en,
    input  logic             fcs_en,
    input  logic [31:0]      crc_val,
    output logic             fifo_rd,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             underflow,
    output logic             crc_init,
    output logic             crc_upd
);
    localparam int CNT_W = $clog2(MIN_BODY + PRE_LEN + FCS_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_BODY);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_LEN - 1);

    txf_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pad_q, fcs_q;
    logic             start_ok;
    logic [CNT_W-1:0] cnt_inc;
    logic             need_pad;
    logic [31:0]      fcs_word;

    assign start_ok = chan_ok && !fifo_empty && (fifo_level >= start_level);
    assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    assign need_pad = pad_q && (cnt_inc < MIN_C);
    assign fcs_word = ~crc_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pad_q   <= 1'b0;
            fcs_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start_ok) begin
                pad_q <= pad_en;
                fcs_q <= fcs_en;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = ST_PRE;
                    cnt_d   = '0;
                end
            end
            ST_PRE: begin
                if (cnt_q == PRE_LAST) begin
                    state_d = ST_SFD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SFD: begin
                state_d = ST_BODY;
                cnt_d   = '0;
            end
            ST_BODY: begin
                if (fifo_empty) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_inc;
                    if (fifo_last) begin
                        if (need_pad) begin
                            state_d = ST_PAD;
                        end else if (fcs_q) begin
                            state_d = ST_FCS;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            ST_PAD: begin
                cnt_d = cnt_inc;
                if (cnt_inc == MIN_C) begin
                    if (fcs_q) begin
                        state_d = ST_FCS;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FCS: begin
                if (cnt_q == FCS_LAST) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fifo_rd   = 1'b0;
        tx_data   = 8'h00;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        underflow = 1'b0;
        crc_init  = 1'b0;
        crc_upd   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                tx_valid = 1'b1;
                tx_data  = PRE_BYTE;
            end
            ST_SFD: begin
                tx_valid = 1'b1;
                tx_data  = SFD_BYTE;
                crc_init = 1'b1;
            end
            ST_BODY: begin
                underflow = fifo_empty;
                tx_valid  = !fifo_empty;
                fifo_rd   = !fifo_empty;
                crc_upd   = !fifo_empty;
                tx_data   = fifo_data;
                tx_last   = !fifo_empty && fifo_last && !fcs_q && !need_pad;
            end
            ST_PAD: begin
                tx_valid = 1'b1;
                crc_upd  = 1'b1;
                tx_last  = !fcs_q && (cnt_inc == MIN_C);
            end
            ST_FCS: begin
                tx_valid = 1'b1;
                tx_data  = fcs_word[{cnt_q[1:0], 3'b000} +: 8];
                tx_last  = (cnt_q == FCS_LAST);
            end
            default: ;
        endcase
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!tx_valid && !fifo_rd && !underflow));
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_ok) |=> (state_q == ST_IDLE));
    assert_pre_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SFD) |-> ($past(state_q) == ST_PRE && $past(cnt_q) == PRE_LAST));
    assert_pad_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD) |-> (pad_q && cnt_q < MIN_C));
    assert_fcs_four_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS && cnt_q == FCS_LAST) |=> (state_q == ST_IDLE));
    assert_fcs_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS) |-> fcs_q);
    assert_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (state_q == ST_IDLE && !underflow));
endmodule

// File: rtl/eth_tx_encap.sv
module eth_tx_encap #(
    parameter int LVL_W    = 8,
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_data,
    input  logic             fifo_last,
    input  logic             fifo_empty,
    output logic             fifo_rd,
    input  logic [LVL_W-1:0] start_level,
    input  logic             chan_ok,
    input  logic             pad_en,
    input  logic             fcs_en,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             underflow
);
    logic [31:0] crc_val;
    logic        crc_init;
    logic        crc_upd;

    txf_ctrl #(
        .LVL_W   (LVL_W),
        .PRE_LEN (PRE_LEN),
        .MIN_BODY(MIN_BODY)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_level (fifo_level),
        .fifo_data  (fifo_data),
        .fifo_last  (fifo_last),
        .fifo_empty (fifo_empty),
        .start_level(start_level),
        .chan_ok    (chan_ok),
        .pad_en     (pad_en),
        .fcs_en     (fcs_en),
        .crc_val    (crc_val),
        .fifo_rd    (fifo_rd),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .underflow  (underflow),
        .crc_init   (crc_init),
        .crc_upd    (crc_upd)
    );

    txf_crc32 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .init (crc_init),
        .upd  (crc_upd),
        .din  (tx_data),
        .crc_o(crc_val)
    );
endmodule

// File: tb/test_eth_tx_encap.sv
`timescale 1ns/1ps
module test_eth_tx_encap;
    localparam int LVL_W = 8;
    localparam int MINB  = 60;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LVL_W-1:0] fifo_level;
    logic [7:0]       fifo_data;
    logic             fifo_last;
    logic             fifo_empty;
    logic             fifo_rd;
    logic [LVL_W-1:0] start_level;
    logic             chan_ok;
    logic             pad_en;
    logic             fcs_en;
    logic [7:0]       tx_data;
    logic             tx_valid;
    logic             tx_last;
    logic             underflow;

    always #2.5 clk = ~clk;

    eth_tx_encap i_eth_tx_encap (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_data(fifo_data),
        .fifo_last(fifo_last), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .start_level(start_level), .chan_ok(chan_ok), .pad_en(pad_en), .fcs_en(fcs_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .underflow(underflow)
    );

    // bench FIFO model
    logic [7:0] f_data [0:255];
    logic       f_last [0:255];
    int wr_ptr = 0;
    int rd_ptr = 0;
    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_level = LVL_W'(wr_ptr - rd_ptr);
    assign fifo_data  = f_data[rd_ptr % 256];
    assign fifo_last  = f_last[rd_ptr % 256];
    always @(posedge clk) if (fifo_rd) rd_ptr <= rd_ptr + 1;

    int n_checks = 0;
    int n_fail   = 0;
    int uf_seen  = 0;
    bit expect_uf = 1'b0;
    logic [8:0] exp_q [$];
    string      exp_tag [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_byte(input logic [7:0] b, input bit last, input string tag);
        exp_q.push_back({last, b});
        exp_tag.push_back(tag);
    endtask

    task automatic push_byte(input logic [7:0] b, input bit last);
        f_data[wr_ptr % 256] = b;
        f_last[wr_ptr % 256] = last;
        wr_ptr = wr_ptr + 1;
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected output byte", {24'h0, tx_data}, 32'h0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk(tx_data == e[7:0], t, "byte value", {24'h0, tx_data}, {24'h0, e[7:0]});
                    chk(tx_last == e[8], "R10", "last marker", {31'h0, tx_last}, {31'h0, e[8]});
                end
            end
            if (underflow) begin
                uf_seen++;
                chk(expect_uf && !tx_valid, "R11", "underflow pulse", {31'h0, tx_valid}, 32'h0);
            end
        end
    end

    task automatic wait_drain();
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            tick();
            t++;
        end
        chk(exp_q.size() == 0, "R5", "frame drain timeout", exp_q.size(), 0);
        repeat (3) tick();
    endtask

    task automatic run_frame(input int len, input bit pad, input bit fcs, input int seed);
        logic [7:0]  body [$];
        logic [31:0] crc;
        int          total;
        for (int i = 0; i < len; i++) body.push_back(8'(seed + i * 37));
        total = len;
        if (pad) while (total < MINB) begin body.push_back(8'h00); total++; end
        crc = 32'hFFFFFFFF;
        foreach (body[i]) crc = crc_step(crc, body[i]);
        crc = ~crc;
        for (int i = 0; i < 7; i++) expect_byte(8'h55, 1'b0, "R3");
        expect_byte(8'hD5, 1'b0, "R4");
        for (int i = 0; i < total; i++)
            expect_byte(body[i], !fcs && (i == total - 1), (i < len) ? "R5" : (pad ? "R6" : "R7"));
        if (fcs) for (int i = 0; i < 4; i++) expect_byte(crc[8*i +: 8], i == 3, "R8");
        for (int i = 0; i < len; i++) push_byte(body[i], i == len - 1);
        start_level = LVL_W'(len);
        pad_en  = pad;
        fcs_en  = fcs;
        chan_ok = 1'b1;
        tick();
        // R2: enables captured at start; flip them now
        pad_en = !pad;
        fcs_en = !fcs;
        wait_drain();
        chan_ok = 1'b0;
        chk(fifo_empty, "R9", "FIFO consumed", {31'h0, fifo_empty}, 32'h1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chan_ok = 1'b0; pad_en = 1'b0; fcs_en = 1'b0; start_level = '0;
        repeat (3) tick();
        chk(!tx_valid && !tx_last && !fifo_rd && !underflow, "R1", "reset state",
            {28'h0, tx_valid, tx_last, fifo_rd, underflow}, 32'h0);
        rst_n = 1'b1;
        repeat (2) tick();
        chk(!tx_valid && !fifo_rd, "R1", "idle after reset", {30'h0, tx_valid, fifo_rd}, 32'h0);

        // R2: threshold not reached
        for (int i = 0; i < 10; i++) push_byte(8'(i + 1), i == 9);
        start_level = 8'd20; chan_ok = 1'b1;
        repeat (8) tick();
        chk(!tx_valid && !fifo_rd, "R2", "no start below threshold", {30'h0, tx_valid, fifo_rd}, 32'h0);
        // R2: channel withheld
        chan_ok = 1'b0; start_level = 8'd10;
        repeat (8) tick();
        chk(!tx_valid && !fifo_rd, "R2", "no start without channel", {30'h0, tx_valid, fifo_rd}, 32'h0);
        // now release: short frame, pad on, fcs on
        begin
            logic [7:0]  body [$];
            logic [31:0] crc;
            for (int i = 0; i < 10; i++) body.push_back(8'(i + 1));
            while (body.size() < MINB) body.push_back(8'h00);
            crc = 32'hFFFFFFFF;
            foreach (body[i]) crc = crc_step(crc, body[i]);
            crc = ~crc;
            for (int i = 0; i < 7; i++) expect_byte(8'h55, 1'b0, "R3");
            expect_byte(8'hD5, 1'b0, "R4");
            foreach (body[i]) expect_byte(body[i], 1'b0, (i < 10) ? "R5" : "R6");
            for (int i = 0; i < 4; i++) expect_byte(crc[8*i +: 8], i == 3, "R8");
            pad_en = 1'b1; fcs_en = 1'b1; chan_ok = 1'b1;
            tick();
            pad_en = 1'b0; fcs_en = 1'b0;
            wait_drain();
            chan_ok = 1'b0;
        end

        run_frame(10, 1'b0, 1'b1, 3);    // R7 short, no pad, with FCS
        run_frame(10, 1'b1, 1'b0, 5);    // R6 pad, R9 no FCS
        run_frame(5,  1'b0, 1'b0, 9);    // R7 + R9
        run_frame(60, 1'b1, 1'b1, 11);   // R6 boundary: no pad bytes
        run_frame(70, 1'b1, 1'b1, 13);   // R8 long frame
        run_frame(59, 1'b1, 1'b0, 17);   // R6 one pad byte, R10 on pad

        // R11: underflow
        for (int i = 0; i < 7; i++) expect_byte(8'h55, 1'b0, "R3");
        expect_byte(8'hD5, 1'b0, "R4");
        for (int i = 0; i < 3; i++) begin
            expect_byte(8'(8'hA0 + i), 1'b0, "R11");
            push_byte(8'(8'hA0 + i), 1'b0);
        end
        start_level = 8'd3; pad_en = 1'b1; fcs_en = 1'b1; expect_uf = 1'b1; chan_ok = 1'b1;
        tick();
        chan_ok = 1'b0;
        wait_drain();
        repeat (10) tick();
        expect_uf = 1'b0;
        chk(uf_seen == 1, "R11", "underflow pulse count", uf_seen, 1);
        chk(!tx_valid, "R11", "silent after underflow", {31'h0, tx_valid}, 32'h0);

        run_frame(12, 1'b1, 1'b1, 21);   // recovery after underflow

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule